// File: doc/BRIEF.md
# Resonance-Tracking Digital PLL with Loop Health Telemetry

This block follows the resonant frequency of a vibrating sensing element. Its input is a stream of signed pickup samples. A phase detector compares each sample against the sign of an internal oscillator. The detector output drives a proportional-integral loop filter, and the filter output sets the step size of a phase accumulator. The step size, called the frequency word, is the block's frequency result. The accumulator value is its phase estimate.

Next to the tracking results the block publishes loop health information:
- a lock flag;
- the active loop mode, either wide acquisition or narrow tracking, each with its own gain pair;
- a saturating count of cycle slips;
- a saturating count of lock losses;
- the number of clock cycles the most recent reacquisition took.

Software programs the two gain pairs. A clear pulse zeroes the diagnostic counters.

The sample input is a valid/ready stream. `s_ready` goes high on the first clock edge after reset is released and then stays high, so the block never applies back-pressure. A sample is consumed on every rising edge where `s_valid` and `s_ready` are both high. The result side has no ready signal. `res_valid` pulses for one cycle after a consumed sample, and only if the loop is locked after that sample. The frequency and phase ports always show the current loop state, but they count as a measurement only when `res_valid` is high.

Top module: `reso_track_dpll`

## Requirements
- R1: `s_ready` is low in reset and high from the first edge after reset is released. On a cycle without an accepted sample, the phase, frequency word, lock flag, slip count and lost count keep their values.
- R2: For each accepted sample the phase error equals the sample when the phase estimate's most significant bit is 0, and equals the negated sample when that bit is 1.
- R3: After reset the frequency word is CENTER_FREQ and the phase is 0. On each accepted sample with error e, three updates happen:
  - the integrator adds Ki·e;
  - the frequency word becomes CENTER_FREQ + Kp·e + integrator, modulo 2^PHASE_W;
  - the phase adds the previous frequency word, modulo 2^PHASE_W.
- R4: Kp and Ki come from the acquisition pair while the loop is unlocked and from the tracking pair while it is locked. The mode is the one in force before the sample.
- R5: While unlocked, lock is declared on the LOCK_N-th consecutive accepted sample with |e| < LOCK_THR. Any other accepted sample restarts the run.
- R6: While locked, lock is lost on the LOSS_M-th consecutive accepted sample with |e| > LOSS_THR. Any other accepted sample restarts the run.
- R7: `mode_id` is 1 (track) whenever `lock` is 1, and 0 (acquire) otherwise.
- R8: `res_valid` is high in the cycle after an accepted sample exactly when `lock` is high after that sample. It is never high otherwise.
- R9: Each error is added to a signed PHASE_W-bit accumulator whose range spans −π to +π. Each wrap of that accumulator past ±π increments `slip_cnt`, which holds at all ones.
- R10: Each 1→0 transition of `lock` increments `lost_cnt`, which holds at all ones.
- R11: After a loss of lock, `reacq_time` is set, at the moment lock returns, to the number of clock cycles `lock` was low. The value is capped at all ones and held until the next relock or clear.
- R12: A `clr_cnt` pulse zeroes `slip_cnt`, `lost_cnt` and `reacq_time` on the next edge. The clear takes priority over any increment on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timebase for the reacquire timer |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready (high after reset) |
| s_sample | input | SAMPLE_W | Signed pickup sample |
| cfg_acq_kp | input | GAIN_W | Proportional gain, acquire mode |
| cfg_acq_ki | input | GAIN_W | Integral gain, acquire mode |
| cfg_trk_kp | input | GAIN_W | Proportional gain, track mode |
| cfg_trk_ki | input | GAIN_W | Integral gain, track mode |
| clr_cnt | input | 1 | Clears slip, lost and reacquire results |
| res_valid | output | 1 | Locked result strobe |
| freq_word | output | PHASE_W | Oscillator frequency word |
| phase_est | output | PHASE_W | Oscillator phase |
| lock | output | 1 | Lock flag |
| mode_id | output | 1 | Loop mode: 0 acquire, 1 track |
| slip_cnt | output | SLIP_W | Cycle-slip count |
| lost_cnt | output | LOST_W | Lock-lost count |
| reacq_time | output | REACQ_W | Cycles of the last reacquisition |

## Verification
Every sample-driven result settles one edge after the sample is accepted. That covers the frequency word, phase, lock, mode, slip count, lost count and `res_valid`. A clear also takes effect on that edge. The reacquire timer advances on every clock edge, with or without a sample.

The bench drives each input just after a falling edge and advances its arithmetic model to what the next rising edge must produce. It then compares every output at the following falling edge. Idle cycles are mixed in between samples, so the one-cycle latency is checked against clock cycles rather than against sample count.

// File: rtl/reso_dpll_pkg.sv
package reso_dpll_pkg;
  typedef enum logic {
    MODE_ACQ = 1'b0,
    MODE_TRK = 1'b1
  } loop_mode_e;
endpackage

// File: rtl/reso_phase_det.sv
// Sign-reference phase detector: the sample is multiplied by the sign of
// the oscillator (MSB of its phase). Also provides the error magnitude.
module reso_phase_det #(
  parameter int SAMPLE_W = 12,
  localparam int ERR_W = SAMPLE_W + 1
) (
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       ref_neg_i,
  output logic signed [ERR_W-1:0]    err_o,
  output logic        [ERR_W-1:0]    err_mag_o
);
  logic signed [ERR_W-1:0] ext;

  always_comb begin
    ext       = ERR_W'(sample_i);
    err_o     = ref_neg_i ? -ext : ext;
    err_mag_o = err_o[ERR_W-1] ? unsigned'(-err_o) : unsigned'(err_o);
  end
endmodule

// File: rtl/reso_pi_filter.sv
// Proportional-integral loop filter with per-mode gain pairs.
module reso_pi_filter
  import reso_dpll_pkg::*;
#(
  parameter int          ERR_W       = 13,
  parameter int          GAIN_W      = 4,
  parameter int          PHASE_W     = 16,
  parameter int unsigned CENTER_FREQ = 2048
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en_i,
  input  loop_mode_e                mode_i,
  input  logic [GAIN_W-1:0]         acq_kp_i,
  input  logic [GAIN_W-1:0]         acq_ki_i,
  input  logic [GAIN_W-1:0]         trk_kp_i,
  input  logic [GAIN_W-1:0]         trk_ki_i,
  input  logic signed [ERR_W-1:0]   err_i,
  output logic [PHASE_W-1:0]        freq_o
);
  localparam int XW = (PHASE_W > ERR_W + GAIN_W + 1) ? PHASE_W : ERR_W + GAIN_W + 1;

  logic [GAIN_W-1:0]       kp, ki;
  logic signed [XW-1:0]    err_x, p_term, i_term;
  logic [PHASE_W-1:0]      integ_q, integ_d, freq_q, freq_d;

  always_comb begin
    kp      = (mode_i == MODE_TRK) ? trk_kp_i : acq_kp_i;
    ki      = (mode_i == MODE_TRK) ? trk_ki_i : acq_ki_i;
    err_x   = XW'(err_i);
    p_term  = err_x * $signed({{(XW-GAIN_W){1'b0}}, kp});
    i_term  = err_x * $signed({{(XW-GAIN_W){1'b0}}, ki});
    integ_d = integ_q + i_term[PHASE_W-1:0];
    freq_d  = PHASE_W'(CENTER_FREQ) + p_term[PHASE_W-1:0] + integ_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      freq_q  <= PHASE_W'(CENTER_FREQ);
    end else if (en_i) begin
      integ_q <= integ_d;
      freq_q  <= freq_d;
    end
  end

  assign freq_o = freq_q;

  // R1: the frequency word only moves on an accepted sample
  assert_freq_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> $stable(freq_o));
endmodule

// File: rtl/reso_nco.sv
// Phase accumulator advanced once per accepted sample.
module reso_nco #(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] freq_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= '0;
    else if (en_i) phase_q <= phase_q + freq_i;
  end

  assign phase_o = phase_q;

  // R1: phase holds on cycles without a sample
  assert_phase_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> $stable(phase_o));
endmodule

// File: rtl/reso_slip_det.sv
// Integrates the phase error over a +/-pi range; every wrap is one slip.
module reso_slip_det #(
  parameter int ERR_W   = 13,
  parameter int PHASE_W = 16,
  parameter int SLIP_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic                    clr_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic [SLIP_W-1:0]       slip_o
);
  logic signed [PHASE_W-1:0] acc_q, err_p, sum;
  logic                      wrap;
  logic [SLIP_W-1:0]         slip_q;

  always_comb begin
    err_p = PHASE_W'(err_i);
    sum   = acc_q + err_p;
    wrap  = (acc_q[PHASE_W-1] == err_p[PHASE_W-1]) && (sum[PHASE_W-1] != acc_q[PHASE_W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      slip_q <= '0;
    end else begin
      if (en_i) acc_q <= sum;
      if (clr_i)                                  slip_q <= '0;
      else if (en_i && wrap && (slip_q != '1))    slip_q <= slip_q + 1'b1;
    end
  end

  assign slip_o = slip_q;

  assert_slip_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(slip_q) == '1 && !$past(clr_i)) |-> (slip_q == '1));
  assert_slip_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_i) |-> (slip_q == '0));
endmodule

// File: rtl/reso_lock_mon.sv
// Lock qualifier with hysteresis, lock-lost counter and reacquire timer.
module reso_lock_mon #(
  parameter int ERR_W    = 13,
  parameter int LOCK_THR = 64,
  parameter int LOSS_THR = 512,
  parameter int LOCK_N   = 8,
  parameter int LOSS_M   = 4,
  parameter int LOST_W   = 8,
  parameter int REACQ_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               clr_i,
  input  logic [ERR_W-1:0]   err_mag_i,
  output logic               lock_o,
  output logic               lock_next_o,
  output logic [LOST_W-1:0]  lost_o,
  output logic [REACQ_W-1:0] reacq_o
);
  localparam int NCW = $clog2(LOCK_N + 1);
  localparam int MCW = $clog2(LOSS_M + 1);

  logic               lock_q, lock_d;
  logic [NCW-1:0]     good_q, good_d;
  logic [MCW-1:0]     bad_q, bad_d;
  logic [LOST_W-1:0]  lost_q;
  logic [REACQ_W-1:0] tmr_q, tmr_inc, reacq_q;
  logic               active_q, fell, relock;

  always_comb begin
    lock_d = lock_q;
    good_d = good_q;
    bad_d  = bad_q;
    if (en_i) begin
      if (!lock_q) begin
        bad_d = '0;
        if (err_mag_i < ERR_W'(LOCK_THR)) begin
          if (good_q == NCW'(LOCK_N - 1)) begin
            lock_d = 1'b1;
            good_d = '0;
          end else begin
            good_d = good_q + 1'b1;
          end
        end else begin
          good_d = '0;
        end
      end else begin
        good_d = '0;
        if (err_mag_i > ERR_W'(LOSS_THR)) begin
          if (bad_q == MCW'(LOSS_M - 1)) begin
            lock_d = 1'b0;
            bad_d  = '0;
          end else begin
            bad_d = bad_q + 1'b1;
          end
        end else begin
          bad_d = '0;
        end
      end
    end
    fell    = lock_q && !lock_d;
    relock  = !lock_q && lock_d && active_q;
    tmr_inc = (tmr_q == '1) ? tmr_q : tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      good_q   <= '0;
      bad_q    <= '0;
      lost_q   <= '0;
      tmr_q    <= '0;
      active_q <= 1'b0;
      reacq_q  <= '0;
    end else begin
      lock_q <= lock_d;
      good_q <= good_d;
      bad_q  <= bad_d;
      if (clr_i)                            lost_q <= '0;
      else if (fell && (lost_q != '1))      lost_q <= lost_q + 1'b1;
      if (fell) begin
        tmr_q    <= '0;
        active_q <= 1'b1;
      end else if (!lock_q && active_q) begin
        if (lock_d) active_q <= 1'b0;
        else        tmr_q    <= tmr_inc;
      end
      if (clr_i)       reacq_q <= '0;
      else if (relock) reacq_q <= tmr_inc;
    end
  end

  assign lock_o      = lock_q;
  assign lock_next_o = lock_d;
  assign lost_o      = lost_q;
  assign reacq_o     = reacq_q;

  assert_lock_needs_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(en_i));
  assert_lost_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lock_q) && !$past(clr_i) && ($past(lost_q) != '1)) |-> (lost_q == $past(lost_q) + 1'b1));
  assert_reacq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr_i) && !$rose(lock_q)) |-> $stable(reacq_q));
endmodule

// File: rtl/reso_track_dpll.sv
module reso_track_dpll
  import reso_dpll_pkg::*;
#(
  parameter int          SAMPLE_W    = 12,
  parameter int          PHASE_W     = 16,
  parameter int          GAIN_W      = 4,
  parameter int          SLIP_W      = 8,
  parameter int          LOST_W      = 8,
  parameter int          REACQ_W     = 16,
  parameter int          LOCK_THR    = 64,
  parameter int          LOSS_THR    = 512,
  parameter int          LOCK_N      = 8,
  parameter int          LOSS_M      = 4,
  parameter int unsigned CENTER_FREQ = 2048
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic signed [SAMPLE_W-1:0] s_sample,
  input  logic [GAIN_W-1:0]          cfg_acq_kp,
  input  logic [GAIN_W-1:0]          cfg_acq_ki,
  input  logic [GAIN_W-1:0]          cfg_trk_kp,
  input  logic [GAIN_W-1:0]          cfg_trk_ki,
  input  logic                       clr_cnt,
  output logic                       res_valid,
  output logic [PHASE_W-1:0]         freq_word,
  output logic [PHASE_W-1:0]         phase_est,
  output logic                       lock,
  output logic                       mode_id,
  output logic [SLIP_W-1:0]          slip_cnt,
  output logic [LOST_W-1:0]          lost_cnt,
  output logic [REACQ_W-1:0]         reacq_time
);
  // PHASE_W must be at least SAMPLE_W + 1 so the error fits the slip range.
  localparam int ERR_W = SAMPLE_W + 1;

  logic                    ready_q, accept, res_valid_q, lock_nxt;
  logic signed [ERR_W-1:0] err;
  logic [ERR_W-1:0]        err_mag;
  loop_mode_e              mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      res_valid_q <= 1'b0;
    end else begin
      ready_q     <= 1'b1;
      res_valid_q <= accept && lock_nxt;
    end
  end

  assign s_ready   = ready_q;
  assign accept    = s_valid && ready_q;
  assign mode      = lock ? MODE_TRK : MODE_ACQ;
  assign mode_id   = mode;
  assign res_valid = res_valid_q;

  reso_phase_det #(.SAMPLE_W(SAMPLE_W)) i_pd (
    .sample_i(s_sample), .ref_neg_i(phase_est[PHASE_W-1]),
    .err_o(err), .err_mag_o(err_mag)
  );

  reso_pi_filter #(
    .ERR_W(ERR_W), .GAIN_W(GAIN_W), .PHASE_W(PHASE_W), .CENTER_FREQ(CENTER_FREQ)
  ) i_filt (
    .clk(clk), .rst_n(rst_n), .en_i(accept), .mode_i(mode),
    .acq_kp_i(cfg_acq_kp), .acq_ki_i(cfg_acq_ki),
    .trk_kp_i(cfg_trk_kp), .trk_ki_i(cfg_trk_ki),
    .err_i(err), .freq_o(freq_word)
  );

  reso_nco #(.PHASE_W(PHASE_W)) i_nco (
    .clk(clk), .rst_n(rst_n), .en_i(accept), .freq_i(freq_word), .phase_o(phase_est)
  );

  reso_slip_det #(.ERR_W(ERR_W), .PHASE_W(PHASE_W), .SLIP_W(SLIP_W)) i_slip (
    .clk(clk), .rst_n(rst_n), .en_i(accept), .clr_i(clr_cnt),
    .err_i(err), .slip_o(slip_cnt)
  );

  reso_lock_mon #(
    .ERR_W(ERR_W), .LOCK_THR(LOCK_THR), .LOSS_THR(LOSS_THR), .LOCK_N(LOCK_N),
    .LOSS_M(LOSS_M), .LOST_W(LOST_W), .REACQ_W(REACQ_W)
  ) i_lock (
    .clk(clk), .rst_n(rst_n), .en_i(accept), .clr_i(clr_cnt), .err_mag_i(err_mag),
    .lock_o(lock), .lock_next_o(lock_nxt), .lost_o(lost_cnt), .reacq_o(reacq_time)
  );

  assert_valid_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> lock);
  assert_valid_after_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(accept));
endmodule

// File: tb/test_reso_track_dpll.sv
module test_reso_track_dpll;
  localparam int W = 12, PW = 16, GW = 4, SW = 4, CW = 8, RW = 8;
  localparam int LOCK_THR = 64, LOSS_THR = 512, LOCK_N = 8, LOSS_M = 4;
  localparam int F0 = 2048;
  localparam int MOD = 1 << PW, HALF = 1 << (PW - 1);
  localparam int SMAX = (1 << SW) - 1, CMAX = (1 << CW) - 1, RMAX = (1 << RW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                s_valid = 1'b0, s_ready, clr_cnt = 1'b0;
  logic signed [W-1:0] s_sample = '0;
  logic [GW-1:0]       acq_kp = '0, acq_ki = '0, trk_kp = '0, trk_ki = '0;
  logic                res_valid, lock, mode_id;
  logic [PW-1:0]       freq_word, phase_est;
  logic [SW-1:0]       slip_cnt;
  logic [CW-1:0]       lost_cnt;
  logic [RW-1:0]       reacq_time;

  reso_track_dpll #(
    .SAMPLE_W(W), .PHASE_W(PW), .GAIN_W(GW), .SLIP_W(SW), .LOST_W(CW), .REACQ_W(RW),
    .LOCK_THR(LOCK_THR), .LOSS_THR(LOSS_THR), .LOCK_N(LOCK_N), .LOSS_M(LOSS_M),
    .CENTER_FREQ(F0)
  ) i_reso_track_dpll (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_sample(s_sample),
    .cfg_acq_kp(acq_kp), .cfg_acq_ki(acq_ki), .cfg_trk_kp(trk_kp), .cfg_trk_ki(trk_ki),
    .clr_cnt(clr_cnt), .res_valid(res_valid), .freq_word(freq_word), .phase_est(phase_est),
    .lock(lock), .mode_id(mode_id), .slip_cnt(slip_cnt), .lost_cnt(lost_cnt),
    .reacq_time(reacq_time)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // requirement-level model state
  int m_phase = 0, m_freq = F0, m_integ = 0, m_acc = 0;
  int m_slip = 0, m_lost = 0, m_reacq = 0, m_tmr = 0, m_good = 0, m_bad = 0;
  bit m_lock = 1'b0, m_act = 1'b0, m_rv = 1'b0;
  int lf = 12345;

  function automatic int wrapm(int x);
    return ((x % MOD) + MOD) % MOD;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R1", "s_ready", int'(s_ready), 1);
    chk("R3", "freq_word", int'(freq_word), m_freq);
    chk("R3", "phase_est", int'(phase_est), m_phase);
    chk("R5", "lock", int'(lock), int'(m_lock));
    chk("R7", "mode_id", int'(mode_id), int'(m_lock));
    chk("R8", "res_valid", int'(res_valid), int'(m_rv));
    chk("R9", "slip_cnt", int'(slip_cnt), m_slip);
    chk("R10", "lost_cnt", int'(lost_cnt), m_lost);
    chk("R11", "reacq_time", int'(reacq_time), m_reacq);
  endtask

  // Drive one cycle (called just after a falling edge), advance the model to
  // what the next rising edge produces, compare at the following falling edge.
  task automatic step(bit v, int s, bit c);
    int err, kp, ki, mag;
    bit lk_old;
    s_valid  = v;
    s_sample = s[W-1:0];
    clr_cnt  = c;
    lk_old   = m_lock;
    m_rv     = 1'b0;
    if (v) begin
      err = (m_phase >= HALF) ? -s : s;                 // R2
      kp  = m_lock ? int'(trk_kp) : int'(acq_kp);       // R4
      ki  = m_lock ? int'(trk_ki) : int'(acq_ki);
      m_integ = wrapm(m_integ + ki * err);
      m_phase = wrapm(m_phase + m_freq);
      m_freq  = wrapm(F0 + kp * err + m_integ);
      m_acc   = m_acc + err;
      if (m_acc >= HALF) begin
        m_acc -= MOD;
        if (m_slip < SMAX) m_slip++;
      end else if (m_acc < -HALF) begin
        m_acc += MOD;
        if (m_slip < SMAX) m_slip++;
      end
      mag = (err < 0) ? -err : err;
      if (!m_lock) begin
        m_bad = 0;
        if (mag < LOCK_THR) begin
          if (m_good == LOCK_N - 1) begin m_lock = 1'b1; m_good = 0; end
          else m_good++;
        end else m_good = 0;
      end else begin
        m_good = 0;
        if (mag > LOSS_THR) begin
          if (m_bad == LOSS_M - 1) begin m_lock = 1'b0; m_bad = 0; end
          else m_bad++;
        end else m_bad = 0;
      end
      m_rv = m_lock;
    end
    if (lk_old && !m_lock && m_lost < CMAX) m_lost++;
    if (lk_old && !m_lock) begin
      m_tmr = 0;
      m_act = 1'b1;
    end else if (!lk_old && m_act) begin
      if (m_lock) begin
        m_reacq = (m_tmr < RMAX) ? m_tmr + 1 : RMAX;
        m_act = 1'b0;
      end else if (m_tmr < RMAX) m_tmr++;
    end
    if (c) begin
      m_slip = 0; m_lost = 0; m_reacq = 0;
    end
    @(negedge clk);
    s_valid = 1'b0;
    clr_cnt = 1'b0;
    check_all();
  endtask

  task automatic send_err(int e);
    step(1'b1, (m_phase >= HALF) ? -e : e, 1'b0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0);
  endtask

  function automatic int next_rand();
    lf = lf * 1103515245 + 12345;
    return (lf >>> 8) & 32'h00ff_ffff;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R1, R3)
    chk("R1", "ready in reset", int'(s_ready), 0);
    chk("R3", "freq in reset", int'(freq_word), F0);
    chk("R3", "phase in reset", int'(phase_est), 0);
    chk("R5", "lock in reset", int'(lock), 0);
    chk("R8", "valid in reset", int'(res_valid), 0);
    chk("R10", "lost in reset", int'(lost_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R5: LOCK_N quiet samples with idle gaps; no lock before the last one
    for (int i = 0; i < LOCK_N - 1; i++) begin
      step(1'b1, 0, 1'b0);
      idle(2);                                      // R1: idle cycles change nothing
    end
    chk("R5", "no lock before N", int'(lock), 0);
    step(1'b1, 0, 1'b0);
    chk("R5", "lock on N-th", int'(lock), 1);
    chk("R7", "track mode", int'(mode_id), 1);
    chk("R8", "valid with lock", int'(res_valid), 1);

    // R6: an interrupted run of large errors keeps lock
    for (int i = 0; i < LOSS_M - 1; i++) send_err(1000);
    send_err(10);
    for (int i = 0; i < LOSS_M - 1; i++) send_err(-1000);
    chk("R6", "still locked", int'(lock), 1);
    send_err(1000);
    chk("R6", "lock lost", int'(lock), 0);
    chk("R10", "lost after loss", int'(lost_cnt), 1);

    // R11: relock after idle time and gaps
    idle(5);
    for (int i = 0; i < LOCK_N; i++) begin
      step(1'b1, 20, 1'b0);
      if (i == 3) idle(3);
    end
    chk("R11", "reacq latched", int'(reacq_time), m_reacq);

    // R9 + R2: same-sign error drives repeated wraps up to saturation
    for (int i = 0; i < 600; i++) send_err(2000);
    chk("R9", "slip saturated", int'(slip_cnt), SMAX);
    for (int i = 0; i < 40; i++) send_err(-2000);
    chk("R9", "slip stays at max", int'(slip_cnt), SMAX);

    // R12: clear, plain and together with a sample
    step(1'b0, 0, 1'b1);
    chk("R12", "slip cleared", int'(slip_cnt), 0);
    chk("R12", "lost cleared", int'(lost_cnt), 0);
    chk("R12", "reacq cleared", int'(reacq_time), 0);
    for (int i = 0; i < 20; i++) step(1'b1, ((m_phase >= HALF) ? -2000 : 2000), (i % 7) == 3);

    // R4 + R3: gain sweeps with mixed quiet and loud bursts, gapped valid
    for (int g = 0; g < 6; g++) begin
      acq_kp = GW'(g + 1); acq_ki = GW'(g % 3);
      trk_kp = GW'(g % 2); trk_ki = GW'((g + 1) % 2);
      for (int k = 0; k < 400; k++) begin
        int r, s;
        r = next_rand();
        if ((k % 60) < 45) s = (r & 63) - 32;
        else s = ((r & 1) != 0) ? -(((r >> 1) & 1023) + 600) : (((r >> 1) & 1023) + 600);
        step((r & 12'h300) != 12'h300, s, (k == 200) && (g == 2));
      end
      chk("R4", "freq after sweep", int'(freq_word), m_freq);
    end

    // R11: reacquire timer saturation
    acq_kp = '0; acq_ki = '0; trk_kp = '0; trk_ki = '0;
    for (int i = 0; i < LOCK_N + 2; i++) step(1'b1, 0, 1'b0);
    chk("R5", "locked before sat test", int'(lock), 1);
    for (int i = 0; i < LOSS_M; i++) send_err(1500);
    chk("R6", "lost before sat test", int'(lock), 0);
    idle(RMAX + 40);
    for (int i = 0; i < LOCK_N; i++) step(1'b1, 0, 1'b0);
    chk("R11", "reacq saturated", int'(reacq_time), RMAX);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule